// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block sits between a microprocessor bus and the serial core of a programmable serial controller. The host side has an active-low chip select, read and write strobes, a control/data select line and separate 8-bit input and output data buses. Control writes load the mode register and the command register. Data writes load a transmit holding byte. Status reads show the buffer flags and the modem input. Data reads return the received byte. While a read is active, an active-low output enable tells board logic to drive the output bus.

The serial shifter and baud clock generation are outside this block. They connect through two valid/ready streams. The transmit stream offers the holding byte while `tx_valid` is high, and the byte moves on a cycle in which `tx_ready` is also high. The receive stream sinks one byte into the receive buffer. `rx_ready` stays low while that buffer holds an unread byte, so the serial core must hold its byte until the host reads the buffer. The modem handshake outputs come straight from command bits. Mode bits [1:0] select synchronous timing (00) or asynchronous timing (any other value).

All strobes are sampled on `clk`. A write is captured at the first clock edge at which it is active. A receive-buffer read releases the buffer at the first clock edge after the read ends.

Top module: `sio_hostif`

## Requirements
- R1: While `rst_n` is low, all registers clear at once, without waiting for a clock edge. After reset: `oe_n`=1, `dout`=0, `dtr_n`=1, `rts_n`=1, `tx_valid`=0, `rx_ready`=1, `mode_q`=0 and `cmd_q`=0.
- R2: `oe_n` is low exactly while `cs_n` and `rd_n` are both low. When `oe_n` is high, `dout` is 0.
- R3: A write happens only while `cs_n` and `wr_n` are both low. Exactly one capture of `din` is made per access, at the first clock edge at which the write is active.
- R4: After reset, the first control write (`ctl_sel`=1) loads `mode_q`. Every later control write loads `cmd_q` and leaves `mode_q` unchanged. `sync_mode` is high exactly when `mode_q[1:0]` is 00.
- R5: `dtr_n` is the inverse of `cmd_q[1]`, and `rts_n` is the inverse of `cmd_q[5]`.
- R6: A status read (`ctl_sel`=1) returns bit 7 = NOT `dsr_n`, bit 0 = transmit holding empty, bit 1 = receive buffer full, and 0 in every other bit.
- R7: A data write (`ctl_sel`=0) loads `tx_data` and raises `tx_valid`. The byte is held until a cycle with `tx_ready` high. A data write while `tx_valid` is high replaces the held byte.
- R8: `rx_ready` is high exactly while the receive buffer is empty. A byte is taken when `rx_valid` and `rx_ready` are both high. A data read returns that byte. The buffer empties at the first clock edge after that read ends.
- R9: A status read does not empty the receive buffer. A control write does not change the transmit holding byte or `tx_valid`. A byte offered while the receive buffer is full is not stored.
- R10: `rst_n` asserted in the middle of operation clears all state. The next control write after reset loads the mode register again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ctl_sel | input | 1 | 1: control/status access, 0: data buffer access |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| oe_n | output | 1 | Output bus enable, active low |
| dsr_n | input | 1 | Data set ready modem input, active low |
| dtr_n | output | 1 | Data terminal ready modem output, active low |
| rts_n | output | 1 | Request to send modem output, active low |
| mode_q | output | 8 | Mode register contents |
| sync_mode | output | 1 | High when synchronous timing is selected |
| cmd_q | output | 8 | Command register contents |
| tx_data | output | 8 | Transmit holding byte |
| tx_valid | output | 1 | Transmit holding byte is present |
| tx_ready | input | 1 | Serial core takes the holding byte |
| rx_data | input | 8 | Received byte from serial core |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive buffer can accept a byte |

## Verification
The bench checks the mode-then-command ordering, both from power-up and after a reset in mid-run. A design that kept sending control writes to the mode register, or that did not rearm after reset, would show the wrong `cmd_q` or `mode_q`. It holds a strobe low with chip select high and expects no write and no output enable; a decoder that ignored select would change the modem pins. It checks that a status read leaves the receive flag set, that a byte offered into a full buffer is dropped, and that a second data write replaces a waiting byte. A design that emptied the buffer on any read would lose data, and one that overwrote a full buffer would corrupt it. Random mixes of bus accesses and stream handshakes are compared against a bench model of all flags and bytes.

// File: rtl/sio_hostif_pkg.sv
package sio_hostif_pkg;
  // One-cycle events produced by the bus decoder
  typedef struct packed {
    logic ctl_wr;      // control write capture
    logic dat_wr;      // data write capture
    logic dat_rd_end;  // data read just finished
  } sio_evt_t;
endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode
  import sio_hostif_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic     ctl_sel,
  output logic     rd_act,
  output sio_evt_t evt
);
  logic wr_act;
  logic wr_q, rd_q, rd_dat_q;
  logic wr_pulse;

  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n;
  assign wr_pulse = wr_act && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      rd_dat_q <= 1'b0;
    end else begin
      wr_q     <= wr_act;
      rd_q     <= rd_act;
      rd_dat_q <= rd_act && !ctl_sel;
    end
  end

  always_comb begin
    evt.ctl_wr     = wr_pulse && ctl_sel;
    evt.dat_wr     = wr_pulse && !ctl_sel;
    evt.dat_rd_end = rd_q && !rd_act && rd_dat_q;
  end

  // R3: a single held write strobe yields one capture only
  a_r3_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.ctl_wr || evt.dat_wr) |=> !(evt.ctl_wr || evt.dat_wr));
endmodule

// File: rtl/sio_ctl_regs.sv
module sio_ctl_regs #(
  parameter int DW      = 8,
  parameter int DTR_BIT = 1,
  parameter int RTS_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cmd_q,
  output logic          sync_mode,
  output logic          dtr_n,
  output logic          rts_n
);
  logic expect_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_mode <= 1'b1;
      mode_q      <= '0;
      cmd_q       <= '0;
    end else if (ctl_wr) begin
      if (expect_mode) begin
        mode_q      <= wdata;
        expect_mode <= 1'b0;
      end else begin
        cmd_q <= wdata;
      end
    end
  end

  assign sync_mode = (mode_q[1:0] == 2'b00);
  assign dtr_n     = !cmd_q[DTR_BIT];
  assign rts_n     = !cmd_q[RTS_BIT];

  // R4: once the mode is taken it never changes until reset
  a_r4_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !expect_mode |=> (!expect_mode && $stable(mode_q)));
  // R5: a command write shows on the modem pins the next cycle
  a_r5_modem_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !expect_mode) |=>
      (dtr_n == !$past(wdata[DTR_BIT]) && rts_n == !$past(wdata[RTS_BIT])));
endmodule

// File: rtl/sio_data_bufs.sv
module sio_data_bufs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_wr,
  input  logic          rd_end,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic [DW-1:0] rx_buf,
  output logic          rx_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else if (dat_wr) begin
      tx_data  <= wdata;
      tx_valid <= 1'b1;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf  <= '0;
      rx_full <= 1'b0;
    end else if (rx_valid && !rx_full) begin
      rx_buf  <= rx_data;
      rx_full <= 1'b1;
    end else if (rd_end) begin
      rx_full <= 1'b0;
    end
  end

  assign rx_ready = !rx_full;

  // R7: a pending byte waits unchanged until taken or replaced
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !dat_wr) |=> (tx_valid && $stable(tx_data)));
  // R8/R9: a full receive buffer keeps its byte until a data read ends
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_end) |=> (rx_full && $stable(rx_buf)));
endmodule

// File: rtl/sio_hostif.sv
module sio_hostif
  import sio_hostif_pkg::*;
#(
  parameter int DW      = 8,
  parameter int DTR_BIT = 1,
  parameter int RTS_BIT = 5,
  parameter int DSR_BIT = 7,
  parameter int TXE_BIT = 0,
  parameter int RXF_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          ctl_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          oe_n,
  input  logic          dsr_n,
  output logic          dtr_n,
  output logic          rts_n,
  output logic [DW-1:0] mode_q,
  output logic          sync_mode,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready
);
  sio_evt_t      evt;
  logic          rd_act;
  logic [DW-1:0] rx_buf;
  logic          rx_full;
  logic [DW-1:0] status;

  sio_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_sel(ctl_sel), .rd_act(rd_act), .evt(evt)
  );

  sio_ctl_regs #(.DW(DW), .DTR_BIT(DTR_BIT), .RTS_BIT(RTS_BIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(evt.ctl_wr), .wdata(din),
    .mode_q(mode_q), .cmd_q(cmd_q), .sync_mode(sync_mode),
    .dtr_n(dtr_n), .rts_n(rts_n)
  );

  sio_data_bufs #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .dat_wr(evt.dat_wr), .rd_end(evt.dat_rd_end),
    .wdata(din), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_buf(rx_buf), .rx_full(rx_full)
  );

  always_comb begin
    status          = '0;
    status[TXE_BIT] = !tx_valid;
    status[RXF_BIT] = rx_full;
    status[DSR_BIT] = !dsr_n;
  end

  assign oe_n = !rd_act;
  assign dout = rd_act ? (ctl_sel ? status : rx_buf) : '0;

  // R9: a status read never empties a full receive buffer
  a_r9_status_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !oe_n && ctl_sel) |=> !rx_ready);
endmodule

// File: tb/tb_sio_hostif.sv
module tb_sio_hostif;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, ctl_sel = 0;
  logic [7:0] din = 0, rx_data = 0;
  logic dsr_n = 1, tx_ready = 0, rx_valid = 0;
  logic [7:0] dout, mode_q, cmd_q, tx_data;
  logic oe_n, dtr_n, rts_n, sync_mode, tx_valid, rx_ready;

  sio_hostif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ctl_sel(ctl_sel), .din(din), .dout(dout), .oe_n(oe_n), .dsr_n(dsr_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .mode_q(mode_q), .sync_mode(sync_mode),
    .cmd_q(cmd_q), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready)
  );

  always #10 clk = !clk;  // 50 MHz

  int vecs = 0, fails = 0;
  // bench model
  logic       m_expect_mode;
  logic [7:0] m_mode, m_cmd, m_tx, m_rx;
  logic       m_tx_full, m_rx_full;

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {!dsr_n, 5'b0, m_rx_full, !m_tx_full};
  endfunction

  task automatic model_reset();
    m_expect_mode = 1; m_mode = 0; m_cmd = 0; m_tx = 0; m_rx = 0;
    m_tx_full = 0; m_rx_full = 0;
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = 0; wr_n = 0; ctl_sel = sel; din = d;
    @(negedge clk);
    cs_n = 1; wr_n = 1;
    if (sel) begin
      if (m_expect_mode) begin m_mode = d; m_expect_mode = 0; end
      else m_cmd = d;
    end else begin
      m_tx = d; m_tx_full = 1;
    end
  endtask

  task automatic bus_read(input logic sel, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cs_n = 0; rd_n = 0; ctl_sel = sel;
    e = sel ? exp_status() : m_rx;
    #1;
    chk(oe_n == 0, "R2 oe_n during read", {7'b0, oe_n}, 8'h00);
    chk(dout == e, tag, dout, e);
    @(negedge clk);
    cs_n = 1; rd_n = 1;
    #1;
    chk(oe_n == 1 && dout == 0, "R2 bus idle after read", dout, 8'h00);
    if (!sel) m_rx_full = 0;
  endtask

  task automatic rx_push(input logic [7:0] v);
    @(negedge clk);
    rx_valid = 1; rx_data = v;
    #1;
    chk(rx_ready == !m_rx_full, "R8 rx_ready", {7'b0, rx_ready}, {7'b0, !m_rx_full});
    @(negedge clk);
    rx_valid = 0;
    if (!m_rx_full) begin m_rx = v; m_rx_full = 1; end
  endtask

  task automatic tx_drain();
    @(negedge clk);
    #1;
    chk(tx_valid == m_tx_full, "R7 tx_valid", {7'b0, tx_valid}, {7'b0, m_tx_full});
    if (m_tx_full) chk(tx_data == m_tx, "R7 tx_data", tx_data, m_tx);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    m_tx_full = 0;
  endtask

  task automatic chk_regs(input string tag);
    #1;
    chk(mode_q == m_mode, {tag, " R4 mode"}, mode_q, m_mode);
    chk(cmd_q == m_cmd, {tag, " R4 cmd"}, cmd_q, m_cmd);
    chk(sync_mode == (m_mode[1:0] == 2'b00), {tag, " R4 sync"}, {7'b0, sync_mode}, m_mode);
    chk(dtr_n == !m_cmd[1] && rts_n == !m_cmd[5], {tag, " R5 modem"}, {6'b0, dtr_n, rts_n}, m_cmd);
    chk(tx_valid == m_tx_full, {tag, " R9 tx_valid"}, {7'b0, tx_valid}, {7'b0, m_tx_full});
    chk(rx_ready == !m_rx_full, {tag, " R8 rx_ready"}, {7'b0, rx_ready}, {7'b0, !m_rx_full});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    dsr_n = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(oe_n == 1 && dout == 0, "R1 bus", dout, 8'h00);
    chk(dtr_n == 1 && rts_n == 1, "R1 modem", {6'b0, dtr_n, rts_n}, 8'h03);
    chk(tx_valid == 0 && rx_ready == 1, "R1 streams", {6'b0, tx_valid, rx_ready}, 8'h01);
    chk(mode_q == 0 && cmd_q == 0, "R1 regs", mode_q | cmd_q, 8'h00);
    rst_n = 1;

    // R4: first control write is the mode, the next the command
    bus_write(1, 8'h4E); chk_regs("R4 first");
    bus_write(1, 8'h22); chk_regs("R4 second");
    // R3: strobe with chip select high is ignored
    @(negedge clk); cs_n = 1; wr_n = 0; ctl_sel = 1; din = 8'h00;
    @(negedge clk); wr_n = 1; chk_regs("R3 no select");
    // R2: read strobe without chip select
    @(negedge clk); rd_n = 0; #1;
    chk(oe_n == 1 && dout == 0, "R2 no select", {7'b0, oe_n}, 8'h01);
    @(negedge clk); rd_n = 1;
    // R6 status with dsr low then high
    bus_read(1, "R6 status dsr on");
    dsr_n = 1;
    bus_read(1, "R6 status dsr off");
    // R7 write, replace, drain
    bus_write(0, 8'hA5); chk_regs("R7 load");
    bus_read(1, "R6 status tx busy");
    bus_write(0, 8'h3C);
    bus_write(1, 8'h02); chk_regs("R9 ctl keeps tx");
    tx_drain();
    chk_regs("R7 drained");
    // R8/R9 receive path
    rx_push(8'h5A);
    rx_push(8'h77);
    bus_read(1, "R9 status keeps rx");
    chk_regs("R9 after status");
    bus_read(0, "R8 data read");
    @(negedge clk); chk_regs("R8 after read");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      dsr_n = 1'($urandom_range(0, 1));
      case (op)
        0: bus_write(1, 8'($urandom));
        1: bus_write(0, 8'($urandom));
        2: bus_read(1, "R6 random status");
        3: bus_read(0, "R8 random data");
        4: rx_push(8'($urandom));
        default: tx_drain();
      endcase
      @(negedge clk);
      chk_regs("random");
    end

    // R10 reset in the middle of operation
    rx_push(8'hC3);
    bus_write(0, 8'h99);
    @(negedge clk); #5 rst_n = 0; #1;
    model_reset();
    chk_regs("R10 async");
    @(negedge clk); rst_n = 1;
    bus_write(1, 8'h4C); chk_regs("R10 mode again");
    bus_write(1, 8'h20); chk_regs("R10 cmd after");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule